// File: doc/BRIEF.md
# Skewed Bit-Serial Column Accumulator

The block adds up one unsigned operand per row of a column of bit-serial processing rows. A single command loads every row's operand, a set of segment-break flags and an operand length L. That one command is then unrolled into a stream of bit steps. The work moves down the column as a diagonal wavefront. At step t, row r handles bit t−r of its own operand. It adds that bit to the partial-sum bit passed down from the row above, and it keeps its own carry. A plain single-instruction column would process one bit of one row at a time and need more than L×ROWS cycles. This block finishes a whole column in ROWS+L+G−1 steps, where G = ceil(log2 ROWS) extra steps carry the growth bits of the sum.

Break flags cut the column into independent segments. Each segment's bottom row produces that segment's sum, least significant bit first. Result bits leave through a valid/ready stream, so a host can combine them into its own totals. The stream carries one bit lane per row, a mask of the lanes that hold a live bit, and the current step number. The host finds the bit index from the step number and the lane. When the host holds `res_ready` low while `res_valid` is high, the whole wavefront freezes. All outputs then stay stable and no bit is lost. Steps in which no lane is live advance without waiting for `res_ready`. The input side takes one command whenever `in_ready` is high, and it ignores `in_valid` while a command is running.

Top module: `col_wave_acc`

## Requirements
- R1: After reset, `in_ready` is 1 and `res_valid` and `res_mask` are 0.
- R2: A command is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the command is complete. `in_valid` and the input data have no effect while `in_ready` is 0.
- R3: Each segment's bottom row emits the sum of the low L bits of every operand in that segment, over L+G bits, where G = ceil(log2 ROWS). Row r's operand is `in_opnd[r*BITS +: BITS]`, and row 0 is the top row.
- R4: The bottom row k of a segment emits bit b of its sum in the beat whose `res_step` equals k+b. Each of the L+G bits is emitted exactly once.
- R5: For r ≥ 1, `in_brk[r]` = 1 makes row r the first row of a new segment. The row above r is then the bottom of the segment before it. `in_brk[0]` has no effect, and row ROWS−1 is always a segment bottom.
- R6: Operand bits at positions L and above have no effect on any result.
- R7: While `res_valid` is 1 and `res_ready` is 0, the next cycle shows the same `res_valid`, `res_bits`, `res_mask` and `res_step`.
- R8: With `res_ready` held at 1, `in_ready` returns to 1 exactly ROWS+L+G−1 clock edges after the accepting edge.
- R9: A `res_mask` bit is set only for a segment-bottom row that is emitting a bit. `res_valid` equals the OR of `res_mask`, and `res_bits` is 0 in every lane whose mask bit is 0.
- R10: An `in_len` of 0, or any value above BITS, is taken as L = BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Block idle, command can be taken |
| in_opnd | input | ROWS*BITS | Operands, row r at bits r*BITS and up |
| in_brk | input | ROWS | Segment-start flags, one per row |
| in_len | input | $clog2(BITS+1) | Operand length L |
| res_valid | output | 1 | At least one live result lane |
| res_ready | input | 1 | Host takes the current beat |
| res_bits | output | ROWS | Result bit per row lane |
| res_mask | output | ROWS | Live lanes of `res_bits` |
| res_step | output | $clog2(ROWS+BITS+G) | Current step number t |

## Verification
A wrong carry, a wrong partial-sum register or a wrong bit address in any row corrupts the sum of that row's segment. The error shows in the first bit of that segment that depends on it, which is no later than L+G beats after that segment's first output. A skewed step counter or a row offset that is out of line moves bits to the wrong `res_step`, so the host would assemble a wrong sum. A break flag that is decoded wrongly shows up as a mask bit in the wrong lane during the same command. A stall that leaks through shows up on the very next cycle as a changed output while `res_ready` is low.

// File: rtl/cwa_pkg.sv
package cwa_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  function automatic int growth_bits(input int rows);
    return (rows > 1) ? $clog2(rows) : 0;
  endfunction
endpackage

// File: rtl/cwa_seq.sv
module cwa_seq
  import cwa_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int BITS = 8,
  parameter int LW   = $clog2(BITS + 1),
  parameter int SW   = $clog2(ROWS + BITS + growth_bits(ROWS))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [LW-1:0] in_len,
  input  logic          res_valid,
  input  logic          res_ready,
  output logic          in_ready,
  output logic          accept,
  output logic          run,
  output logic          adv,
  output logic [SW-1:0] step,
  output logic [LW-1:0] len_q
);
  localparam int G = growth_bits(ROWS);

  seq_state_e    state_q;
  logic [SW-1:0] step_q;
  logic [LW-1:0] len_eff;
  logic [SW:0]   last_step;

  // a looped instruction: one command, expanded into ROWS+L+G-1 bit steps
  assign len_eff   = (in_len == '0 || in_len > LW'(BITS)) ? LW'(BITS) : in_len;
  assign last_step = (SW+1)'(ROWS + G - 2) + (SW+1)'(len_q);

  assign in_ready = (state_q == SEQ_IDLE);
  assign run      = (state_q == SEQ_RUN);
  assign accept   = in_valid && in_ready;
  // the whole wavefront freezes while a live beat waits for the host
  assign adv      = run && !(res_valid && !res_ready);
  assign step     = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      step_q  <= '0;
      len_q   <= LW'(BITS);
    end else if (accept) begin
      state_q <= SEQ_RUN;
      step_q  <= '0;
      len_q   <= len_eff;
    end else if (adv) begin
      if ({1'b0, step_q} == last_step) begin
        state_q <= SEQ_IDLE;
        step_q  <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cwa_row.sv
module cwa_row
  import cwa_pkg::*;
#(
  parameter int ROW  = 0,
  parameter int ROWS = 8,
  parameter int BITS = 8,
  parameter int LW   = $clog2(BITS + 1),
  parameter int SW   = $clog2(ROWS + BITS + growth_bits(ROWS))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_opnd,
  input  logic            seg_head,
  input  logic            run,
  input  logic            adv,
  input  logic [SW-1:0]   step,
  input  logic [LW-1:0]   len,
  input  logic            psum_in,
  output logic            sum_bit,
  output logic            active,
  output logic            psum_q
);
  localparam int G   = growth_bits(ROWS);
  localparam int BIW = (BITS > 1) ? $clog2(BITS) : 1;

  logic [BITS-1:0] opnd_q;
  logic            carry_q;
  logic [SW:0]     rel;
  logic            in_field, a_bit, c_in, p_in, s_bit;

  // this row's bit address trails the command by ROW steps
  assign rel      = {1'b0, step} - (SW+1)'(ROW);
  assign active   = run && ({1'b0, step} >= (SW+1)'(ROW))
                        && (rel < ((SW+1)'(len) + (SW+1)'(G)));
  assign in_field = rel < (SW+1)'(len);
  assign a_bit    = in_field ? opnd_q[rel[BIW-1:0]] : 1'b0;
  assign c_in     = (rel == '0) ? 1'b0 : carry_q;
  assign p_in     = seg_head ? 1'b0 : psum_in;
  assign s_bit    = a_bit ^ p_in ^ c_in;
  assign sum_bit  = active & s_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_q  <= '0;
      carry_q <= 1'b0;
      psum_q  <= 1'b0;
    end else if (load) begin
      opnd_q  <= load_opnd;
      carry_q <= 1'b0;
      psum_q  <= 1'b0;
    end else if (adv && active) begin
      carry_q <= (a_bit & p_in) | (a_bit & c_in) | (p_in & c_in);
      psum_q  <= s_bit;
    end
  end
endmodule

// File: rtl/col_wave_acc.sv
module col_wave_acc
  import cwa_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int BITS = 8,
  localparam int G   = growth_bits(ROWS),
  localparam int LW  = $clog2(BITS + 1),
  localparam int SW  = $clog2(ROWS + BITS + G)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ROWS*BITS-1:0] in_opnd,
  input  logic [ROWS-1:0]      in_brk,
  input  logic [LW-1:0]        in_len,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [ROWS-1:0]      res_bits,
  output logic [ROWS-1:0]      res_mask,
  output logic [SW-1:0]        res_step
);
  logic            accept, run, adv;
  logic [SW-1:0]   step;
  logic [LW-1:0]   len_q;
  logic [ROWS-1:0] brk_q, bottom, sum_bit, active, psum;

  cwa_seq #(.ROWS(ROWS), .BITS(BITS), .LW(LW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_len(in_len),
    .res_valid(res_valid), .res_ready(res_ready), .in_ready(in_ready),
    .accept(accept), .run(run), .adv(adv), .step(step), .len_q(len_q)
  );

  // row 0 always heads a segment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      brk_q <= {ROWS{1'b1}};
    else if (accept) brk_q <= in_brk | ROWS'(1);
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    if (r == ROWS - 1) begin : g_last
      assign bottom[r] = 1'b1;
    end else begin : g_mid
      assign bottom[r] = brk_q[r+1];
    end

    // the chain wraps into row 0, whose head flag always blocks it
    cwa_row #(.ROW(r), .ROWS(ROWS), .BITS(BITS), .LW(LW), .SW(SW)) u_row (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .load_opnd(in_opnd[r*BITS +: BITS]), .seg_head(brk_q[r]),
      .run(run), .adv(adv), .step(step), .len(len_q),
      .psum_in(psum[(r + ROWS - 1) % ROWS]),
      .sum_bit(sum_bit[r]), .active(active[r]), .psum_q(psum[r])
    );
  end

  assign res_mask  = active & bottom;
  assign res_bits  = sum_bit & res_mask;
  assign res_valid = |res_mask;
  assign res_step  = step;
endmodule

// File: rtl/cwa_chk.sv
module cwa_chk #(
  parameter int ROWS = 8,
  parameter int SW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [ROWS-1:0] res_bits,
  input logic [ROWS-1:0] res_mask,
  input logic [SW-1:0]   res_step,
  input logic [ROWS-1:0] brk_q,
  input logic            run,
  input logic            adv
);
  logic [ROWS-1:0] bot;
  always_comb begin
    for (int r = 0; r < ROWS; r++)
      bot[r] = (r == ROWS - 1) ? 1'b1 : brk_q[(r + 1) % ROWS];
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R2
  busy_while_emitting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_bits)
                                   && $stable(res_mask) && $stable(res_step)));

  // R9
  mask_at_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_mask & ~bot) == '0);

  // R4
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && adv) |=> (!run || res_step == SW'($past(res_step) + 1'b1)));
endmodule

bind col_wave_acc cwa_chk #(.ROWS(ROWS), .SW(SW)) u_cwa_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_bits(res_bits),
  .res_mask(res_mask), .res_step(res_step), .brk_q(brk_q),
  .run(run), .adv(adv)
);

// File: tb/test_col_wave_acc.sv
module test_col_wave_acc;
  localparam int ROWS = 8;
  localparam int BITS = 8;
  localparam int G    = 3;
  localparam int LW   = 4;
  localparam int SW   = 5;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [ROWS*BITS-1:0] in_opnd = '0;
  logic [ROWS-1:0]      in_brk = '0;
  logic [LW-1:0]        in_len = '0;
  logic                 res_valid;
  logic                 res_ready = 1'b0;
  logic [ROWS-1:0]      res_bits, res_mask;
  logic [SW-1:0]        res_step;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  col_wave_acc #(.ROWS(ROWS), .BITS(BITS)) i_col_wave_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opnd(in_opnd), .in_brk(in_brk), .in_len(in_len),
    .res_valid(res_valid), .res_ready(res_ready), .res_bits(res_bits),
    .res_mask(res_mask), .res_step(res_step)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [ROWS*BITS-1:0] mk(input int seed);
    logic [ROWS*BITS-1:0] v;
    for (int r = 0; r < ROWS; r++) v[r*BITS +: BITS] = BITS'(r * 53 + seed * 29 + 7);
    return v;
  endfunction

  // mode 0: ready held; 1: ready alternates; 2: junk command held while busy
  task automatic run_job(input logic [ROWS*BITS-1:0] opnd, input logic [ROWS-1:0] brk,
                         input int len, input int mode, input string req);
    int L, T, cyc, acc, idx, mask_bad;
    int exp_s[ROWS], got[ROWS], cnt[ROWS], first[ROWS];
    bit isbot[ROWS];
    bit stall_prev, rdy;
    logic [ROWS-1:0] pb, pm;
    logic [SW-1:0]   ps;
    L = (len == 0 || len > BITS) ? BITS : len;
    T = ROWS + L + G - 1;
    acc = 0;
    for (int r = 0; r < ROWS; r++) begin
      if (r == 0 || brk[r]) acc = 0;
      acc += int'(opnd[r*BITS +: BITS]) & ((1 << L) - 1);
      isbot[r] = (r == ROWS - 1) || brk[(r + 1) % ROWS];
      exp_s[r] = isbot[r] ? acc : 0;
      got[r] = 0; cnt[r] = 0; first[r] = -1;
    end
    @(negedge clk);
    in_opnd = opnd; in_brk = brk; in_len = LW'(len); in_valid = 1'b1;
    res_ready = (mode != 1);
    @(posedge clk);
    @(negedge clk);
    if (mode == 2) begin in_opnd = ~opnd; in_brk = ~brk; in_len = 4'd1; end
    else in_valid = 1'b0;
    check(!in_ready, "R2", "ready low after accept", int'(in_ready), 0);
    cyc = 0; stall_prev = 0; mask_bad = 0;
    forever begin
      if (cyc > 0) @(negedge clk);
      if (in_ready) break;
      cyc++;
      if (stall_prev)
        check(res_valid && res_bits == pb && res_mask == pm && res_step == ps,
              "R7", "beat held under stall", int'(res_bits), int'(pb));
      if (res_valid != (|res_mask)) mask_bad++;
      for (int k = 0; k < ROWS; k++)
        if ((res_mask[k] && !isbot[k]) || (!res_mask[k] && res_bits[k])) mask_bad++;
      rdy = (mode == 1) ? cyc[0] : 1'b1;
      res_ready = rdy;
      stall_prev = res_valid && !rdy;
      pb = res_bits; pm = res_mask; ps = res_step;
      if (res_valid && rdy)
        for (int k = 0; k < ROWS; k++)
          if (res_mask[k]) begin
            idx = int'(res_step) - k;
            if (first[k] < 0) first[k] = int'(res_step);
            if (idx < 0 || idx >= L + G) mask_bad++;
            else got[k] |= int'(res_bits[k]) << idx;
            cnt[k]++;
          end
    end
    in_valid = 1'b0;
    res_ready = 1'b0;
    check(mask_bad == 0, "R9", "lane mask and valid consistency", mask_bad, 0);
    for (int k = 0; k < ROWS; k++)
      if (isbot[k]) begin
        check(got[k] == exp_s[k], req, $sformatf("sum at row %0d", k), got[k], exp_s[k]);
        check(cnt[k] == L + G, "R4", $sformatf("bit count row %0d", k), cnt[k], L + G);
        check(first[k] == k, "R4", $sformatf("first bit step row %0d", k), first[k], k);
      end else begin
        check(cnt[k] == 0, "R5", $sformatf("no output from inner row %0d", k), cnt[k], 0);
      end
    if (mode != 1) check(cyc == T, "R8", "busy cycles", cyc, T);
    else check(cyc > T, "R7", "stalls lengthen the run", cyc, T + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(res_valid == 1'b0, "R1", "res_valid after reset", int'(res_valid), 0);
    check(res_mask == '0, "R1", "res_mask after reset", int'(res_mask), 0);
  endtask

  task automatic t_single();   // R3 R8: full column, largest sum
    run_job({ROWS*BITS{1'b1}}, '0, BITS, 0, "R3");
  endtask

  task automatic t_halves();   // R5: two four-row segments
    run_job(mk(1), 8'b0001_0000, BITS, 0, "R5");
  endtask

  task automatic t_each();     // R5 R9: every row its own segment, brk[0] set
    run_job(mk(2), 8'hFF, BITS, 0, "R5");
  endtask

  task automatic t_short();    // R6: high bits set beyond L=3
    run_job({ROWS*BITS{1'b1}}, 8'b0100_0100, 3, 0, "R6");
    run_job(mk(3), '0, 5, 0, "R6");
  endtask

  task automatic t_len_clamp(); // R10: 0 and values above BITS mean BITS
    run_job(mk(4), '0, 0, 0, "R10");
    run_job(mk(5), 8'b0000_1000, 12, 0, "R10");
  endtask

  task automatic t_stall();    // R7: host ready every other cycle
    run_job(mk(6), 8'b0010_0100, BITS, 1, "R7");
  endtask

  task automatic t_busy();     // R2: junk command held during the run
    run_job(mk(7), 8'b1000_0010, 6, 2, "R2");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_halves();
    t_each();
    t_short();
    t_len_clamp();
    t_stall();
    t_busy();
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule